// File: doc/BRIEF.md
# Floating-Point NaN Result Generator

This unit sits at the tail of a single-precision arithmetic pipeline. It picks the exact 32-bit pattern of a result once that result is NaN. It receives up to three operands, an arity code that says which operands the operation reads, an indication from the datapath that the arithmetic itself produced an invalid result (for example infinity minus infinity), and a policy select. It sorts each operand into NaN, signaling NaN or ordinary value. It then applies the selected policy and registers a result pattern, a NaN indication and an invalid-operation flag one clock later.

Three policies are offered. The fixed-canonical policy always emits the positive quiet NaN whose only set mantissa bit is the top one. The canonical-keeping policy emits that canonical value while every NaN operand carries the canonical payload; otherwise it emits the highest-priority NaN operand after quieting. The propagating policy always forwards the highest-priority NaN operand after quieting. Sign-manipulation operations do not pass through this unit; the surrounding pipeline routes them around it.

Top module: `nan_result_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `valid_out`, `result_nan`, `invalid_flag` and `nan_out` are all cleared to zero.
- R2: Results appear one clock after `valid_in` is sampled high, and `valid_out` is high in exactly that cycle. The `mode`, `arity` and operands are sampled with that same `valid_in`. On a clock where `valid_in` is low, `valid_out` goes low and `nan_out`, `result_nan` and `invalid_flag` keep their values.
- R3: An operand is NaN when bits 30:23 are all ones and bits 22:0 are nonzero; all ones with a zero mantissa is infinity and is not NaN. `arity` 0 reads only `src_a`, 1 reads `src_a` and `src_b`, and 2 or 3 read all three operands. Operands that are not read have no effect on any output. `result_nan` is 1 when a read operand is NaN or `invalid_in` is 1.
- R4: With `mode` 0 (fixed canonical), every NaN result is 0x7FC00000.
- R5: With `mode` 1 (canonical keeping), the result is 0x7FC00000 when every read NaN operand has mantissa exactly 0x400000, whatever its sign, and also when no operand is NaN. Otherwise the result is the highest-priority read NaN operand after quieting.
- R6: With `mode` 2 or 3 (propagate) and three operands, `src_c` (the addend) has priority over `src_a`, and `src_a` has priority over `src_b`. The chosen NaN is output after quieting.
- R7: With `mode` 2 or 3 and one or two operands, `src_a` has priority over `src_b`. When no read operand is NaN but `invalid_in` is 1, the result is 0x7FC00000.
- R8: Quieting sets bit 22 and leaves the sign bit and mantissa bits 21:0 unchanged, so every NaN result has bit 22 set.
- R9: `invalid_flag` is 1 when any read operand is a signaling NaN (NaN with bit 22 clear) or `invalid_in` is 1.
- R10: When the result is not NaN, `nan_out` is 0 and `invalid_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Inputs are presented this cycle |
| mode | input | 2 | NaN policy: 0 fixed canonical, 1 canonical keeping, 2/3 propagate |
| arity | input | 2 | Operands read: 0 one, 1 two, 2/3 three (fused multiply-add) |
| invalid_in | input | 1 | Datapath reports an invalid arithmetic result |
| src_a | input | 32 | Source 1 / multiplicand |
| src_b | input | 32 | Source 2 / multiplier |
| src_c | input | 32 | Addend (three-operand case) |
| valid_out | output | 1 | Registered result is valid |
| result_nan | output | 1 | Result is NaN |
| nan_out | output | 32 | NaN result pattern, zero when the result is not NaN |
| invalid_flag | output | 1 | Invalid-operation flag |

## Verification
Payload selection and the invalid flag can be decided by different operands in the same cycle. A quiet NaN in a high-priority slot supplies the payload, while a signaling NaN in a lower-priority slot raises the flag. The sweep covers every operand triple drawn from a small set of values (ordinary, infinity, canonical and non-canonical quiet NaNs, signaling NaNs of both signs), under every arity, every mode and both states of `invalid_in`. This includes exactly those mixed cases. For each vector the bench works out the payload owner and the flag on their own and compares both in the result cycle. It then drives an idle cycle with altered inputs to confirm the results are held.

// File: rtl/nan_gen_pkg.sv
package nan_gen_pkg;

  typedef enum logic [1:0] {
    POL_CANON  = 2'd0,
    POL_KEEP   = 2'd1,
    POL_PROP   = 2'd2,
    POL_PROP_X = 2'd3
  } policy_e;

  typedef enum logic [1:0] {
    AR_ONE   = 2'd0,
    AR_TWO   = 2'd1,
    AR_FMA   = 2'd2,
    AR_FMA_X = 2'd3
  } arity_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic canon_pay;
  } nan_info_t;

endpackage

// File: rtl/nan_classify.sv
module nan_classify
  import nan_gen_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] op,
  output nan_info_t            info
);
  localparam int W = EXP_W + MAN_W + 1;
  localparam logic [MAN_W-1:0] CANON_MAN = {1'b1, {(MAN_W-1){1'b0}}};

  logic exp_max;
  logic man_nz;

  always_comb begin
    exp_max        = &op[W-2:MAN_W];
    man_nz         = |op[MAN_W-1:0];
    info.is_nan    = exp_max && man_nz;
    info.is_snan   = exp_max && man_nz && !op[MAN_W-1];
    info.canon_pay = (op[MAN_W-1:0] == CANON_MAN);
  end
endmodule

// File: rtl/nan_pick.sv
module nan_pick
  import nan_gen_pkg::*;
#(
  parameter int W = 32,
  parameter int N = 3
) (
  input  logic [N-1:0][W-1:0] ops,
  input  nan_info_t [N-1:0]   info,
  input  logic [N-1:0]        read_mask,
  output logic                any_nan,
  output logic                any_snan,
  output logic                all_canon,
  output logic [W-1:0]        chosen
);
  // Slot 0 has the highest priority: scan from the lowest so it wins last.
  always_comb begin
    any_nan   = 1'b0;
    any_snan  = 1'b0;
    all_canon = 1'b1;
    chosen    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (read_mask[i] && info[i].is_nan) begin
        any_nan = 1'b1;
        chosen  = ops[i];
        if (info[i].is_snan)    any_snan  = 1'b1;
        if (!info[i].canon_pay) all_canon = 1'b0;
      end
    end
  end
endmodule

// File: rtl/nan_result_gen.sv
module nan_result_gen
  import nan_gen_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   valid_in,
  input  logic [1:0]             mode,
  input  logic [1:0]             arity,
  input  logic                   invalid_in,
  input  logic [EXP_W+MAN_W:0]   src_a,
  input  logic [EXP_W+MAN_W:0]   src_b,
  input  logic [EXP_W+MAN_W:0]   src_c,
  output logic                   valid_out,
  output logic                   result_nan,
  output logic [EXP_W+MAN_W:0]   nan_out,
  output logic                   invalid_flag
);
  localparam int W      = EXP_W + MAN_W + 1;
  localparam int NSLOT  = 3;
  localparam int QBIT   = MAN_W - 1;
  localparam logic [W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [NSLOT-1:0][W-1:0] slot;
  logic [NSLOT-1:0]        read_mask;
  nan_info_t [NSLOT-1:0]   info;
  logic                    any_nan, any_snan, all_canon;
  logic [W-1:0]            chosen, quieted, pattern;
  logic                    nan_d, flag_d;

  // Order operands by priority for the current arity.
  always_comb begin
    unique case (arity_e'(arity))
      AR_ONE: begin
        slot      = {src_c, src_b, src_a};
        read_mask = 3'b001;
      end
      AR_TWO: begin
        slot      = {src_c, src_b, src_a};
        read_mask = 3'b011;
      end
      default: begin
        slot      = {src_b, src_a, src_c};
        read_mask = 3'b111;
      end
    endcase
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_cls
    nan_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op   (slot[g]),
      .info (info[g])
    );
  end

  nan_pick #(.W(W), .N(NSLOT)) u_pick (
    .ops       (slot),
    .info      (info),
    .read_mask (read_mask),
    .any_nan   (any_nan),
    .any_snan  (any_snan),
    .all_canon (all_canon),
    .chosen    (chosen)
  );

  always_comb begin
    quieted       = chosen;
    quieted[QBIT] = 1'b1;
    nan_d         = any_nan || invalid_in;
    flag_d        = any_snan || invalid_in;
    pattern       = '0;
    if (nan_d) begin
      unique case (policy_e'(mode))
        POL_CANON: pattern = CANON;
        POL_KEEP:  pattern = all_canon ? CANON : quieted;
        default:   pattern = any_nan ? quieted : CANON;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out    <= 1'b0;
      result_nan   <= 1'b0;
      nan_out      <= '0;
      invalid_flag <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        result_nan   <= nan_d;
        nan_out      <= pattern;
        invalid_flag <= flag_d;
      end
    end
  end
endmodule

// File: rtl/nan_result_gen_chk.sv
module nan_result_gen_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 valid_in,
  input logic [1:0]           mode,
  input logic [1:0]           arity,
  input logic [EXP_W+MAN_W:0] src_c,
  input logic                 valid_out,
  input logic                 result_nan,
  input logic [EXP_W+MAN_W:0] nan_out,
  input logic                 invalid_flag
);
  localparam int W = EXP_W + MAN_W + 1;
  localparam logic [W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic c_snan;
  always_comb c_snan = (&src_c[W-2:MAN_W]) && !src_c[MAN_W-1] && (|src_c[MAN_W-2:0]);

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> valid_out == $past(valid_in));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(valid_in)) |-> ($stable(nan_out) && $stable(invalid_flag) && $stable(result_nan)));

  // R4
  canon_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(valid_in) && $past(mode) == 2'd0) |-> (nan_out == '0 || nan_out == CANON));

  // R8
  quiet_out_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_out && result_nan) |-> (nan_out[MAN_W-1] && (&nan_out[W-2:MAN_W])));

  // R10
  not_nan_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_out && !result_nan) |-> (nan_out == '0 && !invalid_flag));

  // R9
  addend_snan_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(valid_in) && $past(arity[1]) && $past(c_snan)) |-> invalid_flag);
endmodule

bind nan_result_gen nan_result_gen_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .valid_in     (valid_in),
  .mode         (mode),
  .arity        (arity),
  .src_c        (src_c),
  .valid_out    (valid_out),
  .result_nan   (result_nan),
  .nan_out      (nan_out),
  .invalid_flag (invalid_flag)
);

// File: tb/sim_nan_result_gen.sv
module sim_nan_result_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [1:0]  mode = '0;
  logic [1:0]  arity = '0;
  logic        invalid_in = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, src_c = '0;
  logic        valid_out, result_nan, invalid_flag;
  logic [31:0] nan_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] CANON = 32'h7FC0_0000;

  always #10 clk = ~clk;

  nan_result_gen u0 (
    .clk(clk), .rst(rst), .valid_in(valid_in), .mode(mode), .arity(arity),
    .invalid_in(invalid_in), .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .valid_out(valid_out), .result_nan(result_nan), .nan_out(nan_out),
    .invalid_flag(invalid_flag)
  );

  function automatic logic [31:0] val(input int k);
    case (k)
      0: val = 32'h3F80_0000;   // +1.0
      1: val = 32'h7F80_0000;   // +inf
      2: val = 32'hFF80_0000;   // -inf
      3: val = 32'h7FC0_0000;   // canonical quiet
      4: val = 32'hFFC0_0000;   // canonical payload, negative
      5: val = 32'h7FC1_2345;   // quiet with payload
      6: val = 32'h7F80_0001;   // signaling
      7: val = 32'hFFA0_0005;   // signaling, negative
      default: val = 32'h0000_0000;
    endcase
  endfunction

  function automatic logic is_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] s0, s1, s2;
    logic [2:0]  msk;
    logic        any_n, any_s, all_c, e_nan, e_flag, pick_snan;
    logic [31:0] pick, e_pat, held_pat;
    logic        held_nan, held_flag;
    string       tag;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 valid_out", {31'b0, valid_out}, 32'd0);
    chk("R1 nan_out", nan_out, 32'd0);
    chk("R1 flags", {30'b0, result_nan, invalid_flag}, 32'd0);
    rst = 1'b0;

    for (int ia = 0; ia < 9; ia++)
    for (int ib = 0; ib < 9; ib++)
    for (int ic = 0; ic < 9; ic++)
    for (int ar = 0; ar < 4; ar++)
    for (int md = 0; md < 4; md++)
    for (int iv = 0; iv < 2; iv++) begin
      // expected value from requirements R3..R10
      if (ar >= 2) begin s0 = val(ic); s1 = val(ia); s2 = val(ib); msk = 3'b111; end
      else begin s0 = val(ia); s1 = val(ib); s2 = val(ic); msk = (ar == 1) ? 3'b011 : 3'b001; end
      any_n = 0; any_s = 0; all_c = 1; pick = '0; pick_snan = 0;
      for (int k = 2; k >= 0; k--) begin
        logic [31:0] v;
        v = (k == 0) ? s0 : (k == 1) ? s1 : s2;
        if (msk[k] && is_nan(v)) begin
          any_n = 1;
          pick = v;
          pick_snan = !v[22];
          if (!v[22]) any_s = 1;
          if (v[22:0] != 23'h40_0000) all_c = 0;
        end
      end
      e_nan  = any_n || (iv == 1);
      e_flag = any_s || (iv == 1);
      if (!e_nan) begin e_pat = '0; tag = "R10 pattern"; end
      else if (md == 0) begin e_pat = CANON; tag = "R4 pattern"; end
      else if (md == 1) begin
        e_pat = all_c ? CANON : (pick | 32'h0040_0000);
        tag = "R5 pattern";
      end else begin
        e_pat = any_n ? (pick | 32'h0040_0000) : CANON;
        tag = (ar >= 2) ? "R6 pattern" : "R7 pattern";
      end
      if (e_nan && md != 0 && any_n && pick_snan && !(md == 1 && all_c)) tag = "R8 quieted pattern";

      @(negedge clk);
      valid_in = 1'b1; mode = md[1:0]; arity = ar[1:0]; invalid_in = iv[0];
      src_a = val(ia); src_b = val(ib); src_c = val(ic);
      @(negedge clk);
      chk("R2 valid_out", {31'b0, valid_out}, 32'd1);
      chk("R3 result_nan", {31'b0, result_nan}, {31'b0, e_nan});
      chk(tag, nan_out, e_pat);
      chk("R9 invalid_flag", {31'b0, invalid_flag}, {31'b0, e_flag});
      held_pat = nan_out; held_nan = result_nan; held_flag = invalid_flag;

      // idle cycle with disturbed inputs: outputs must hold
      valid_in = 1'b0; mode = ~md[1:0]; arity = ~ar[1:0]; invalid_in = ~iv[0];
      src_a = val(6); src_b = val(7); src_c = val(5);
      @(negedge clk);
      chk("R2 idle valid_out", {31'b0, valid_out}, 32'd0);
      chk("R2 idle nan_out", nan_out, held_pat);
      chk("R2 idle flags", {30'b0, result_nan, invalid_flag}, {30'b0, held_nan, held_flag});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule